// File: doc/BRIEF.md
# I2C Master Register and Interrupt Unit

This block is the bus-facing front end of a FIFO-based I2C master. A 32-bit processor bus reads and writes a small set of word registers: a control word, the target address, the transfer length, byte ports into a transmit FIFO and out of a receive FIFO, a status word, a high-speed configuration word, a fixed version word, two divider words, a start-hold word and a FIFO flush register. The serial bit engine and the SCL timer are outside the block. They read its configuration outputs, pop transmit bytes, push received bytes and report busy, done and NACK through single-cycle strobes and level inputs.

The block drives one interrupt line. The line combines a sticky transfer-done flag with two FIFO watermark conditions, each with its own enable and a programmable 4-bit level. The sticky status flags are cleared by writing 0 to their bit, so software clears them by read-modify-write. The stop request is carried as an inverted control bit: setting it asks the engine to hold the bus without a stop condition.

A bus access has a setup cycle (select high, enable low) and an access cycle (select and enable high). A write takes effect at the clock edge that ends the access cycle. Read data is valid combinationally during the access cycle.

Top module: `i2cm_csr_unit`

## Requirements
- R1: After reset the control word reads 0 and the status word reads only the transmit-empty flag (bit 3) together with the live SCL (bit 20) and SDA (bit 21) input levels. The version word at 0x1C reads the VERSION parameter.
- R2: The control word at 0x00 stores the writable mask 0x001F_FFDF. The bits are: start 0, interrupt gate 1, enable 2, read direction 3, high-speed 4, trim 6, output option 7, divider option 8, empty-watermark enable 9, full-watermark enable 10, DMA 11, empty level 15:12, full level 19:16, stop-suppress 20. Bits 5 and 31:21 read 0. The outputs cfg_start, cfg_enable, cfg_read and cfg_opts follow the stored bits.
- R3: The target word at 0x04 keeps bits 7:1 and reads bit 0 as 0. cfg_target carries bits 7:1. The count word at 0x08 keeps its low CNT_W bits, and the high-speed word at 0x18 keeps its low 16 bits.
- R4: The version word is read-only, and a write to it leaves its value unchanged.
- R5: Status bit 2 (pending) is set by eng_done and bit 1 (NACK) is set by eng_nack. Writing 0 to either bit clears it and writing 1 keeps it. When an engine set falls in the same cycle as a clearing write, the set wins.
- R6: Bytes written to the transmit port at 0x10 appear on tx_byte in write order, and each eng_tx_pop advances to the next byte. A write to a full transmit FIFO is dropped.
- R7: Reads of the receive port at 0x0C return pushed bytes in order, one per access. A read of an empty FIFO returns 0. Status bit 4 shows that the receive FIFO is full.
- R8: Writing 1 to bit 0 of the flush register at 0x2C empties both FIFOs.
- R9: irq equals the interrupt gate AND (pending OR (full-watermark enable AND receive occupancy >= full level) OR (empty-watermark enable AND transmit occupancy <= empty level)).
- R10: scl_high_cnt is {word 0x24 bits 31:16, word 0x20 bits 31:16}, scl_low_cnt is {word 0x24 bits 15:0, word 0x20 bits 15:0}, and start_hold is word 0x28.
- R11: The start bit stays set while the engine runs and finishes. Only a software write clears it.
- R12: cfg_send_stop is the inverse of control bit 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus select |
| bus_en | input | 1 | Bus access phase |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| eng_busy | input | 1 | Engine busy level |
| eng_done | input | 1 | Transfer-done strobe |
| eng_nack | input | 1 | NACK-received strobe |
| eng_tx_pop | input | 1 | Engine takes the transmit head byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| tx_byte | output | 8 | Transmit head byte |
| tx_avail | output | 1 | Transmit FIFO not empty |
| rx_space | output | 1 | Receive FIFO not full |
| cfg_start | output | 1 | Start request |
| cfg_enable | output | 1 | Controller enable |
| cfg_read | output | 1 | Read direction |
| cfg_send_stop | output | 1 | Issue stop at end of transfer |
| cfg_opts | output | 5 | {DMA, divider opt, output opt, trim, high-speed} |
| cfg_target | output | 7 | Target address |
| cfg_count | output | 16 | Transfer length |
| cfg_hs | output | 16 | High-speed configuration |
| scl_high_cnt | output | 32 | SCL high period |
| scl_low_cnt | output | 32 | SCL low period |
| start_hold | output | 32 | Start hold time |
| irq | output | 1 | Interrupt line |

## Verification
The status flags are where two functions can fall in the same cycle: an engine set strobe and a software write that clears the same bit. The bench provokes this by raising eng_done, or eng_nack, in the exact access cycle of a status write with that bit at 0. It judges the result by reading the flag back, which must still be 1. A second write of 0 with no strobe must then clear it. Constrained-random sequences of control writes, FIFO pushes and pops then compare irq after every operation with a model built from the occupancies the bench tracks.

// File: rtl/i2cm_csr_pkg.sv
package i2cm_csr_pkg;

   localparam int ADDR_W = 6;

   typedef enum logic [3:0] {
      RI_CTL  = 4'd0,
      RI_TGT  = 4'd1,
      RI_CNT  = 4'd2,
      RI_RXP  = 4'd3,
      RI_TXP  = 4'd4,
      RI_STS  = 4'd5,
      RI_HSC  = 4'd6,
      RI_VER  = 4'd7,
      RI_DVL  = 4'd8,
      RI_DVH  = 4'd9,
      RI_HLD  = 4'd10,
      RI_FRST = 4'd11
   } reg_idx_e;

   // control word bit positions
   localparam int CB_START  = 0;
   localparam int CB_GIE    = 1;
   localparam int CB_EN     = 2;
   localparam int CB_READ   = 3;
   localparam int CB_HS     = 4;
   localparam int CB_TRIM   = 6;
   localparam int CB_OUT    = 7;
   localparam int CB_DVD    = 8;
   localparam int CB_EIE    = 9;
   localparam int CB_FIE    = 10;
   localparam int CB_DMA    = 11;
   localparam int CB_AE_LO  = 12;
   localparam int CB_AF_LO  = 16;
   localparam int CB_NOSTOP = 20;
   localparam logic [31:0] CTL_WMASK = 32'h001F_FFDF;

   // status word bit positions
   localparam int SB_BUSY = 0;
   localparam int SB_NACK = 1;
   localparam int SB_PEND = 2;
   localparam int SB_TXE  = 3;
   localparam int SB_RXF  = 4;
   localparam int SB_SCL  = 20;
   localparam int SB_SDA  = 21;

   localparam int LVL_W = 4;

endpackage

// File: rtl/i2cm_byte_fifo.sv
module i2cm_byte_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == FULL_CNT);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push && !flush) begin
         mem[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) begin
            wr_ptr <= wr_ptr + 1'b1;
         end
         if (do_pop) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/i2cm_irq_gen.sv
module i2cm_irq_gen #(
   parameter int  CW      = 5,
   parameter int  LVL_W   = 4,
   parameter bit  REG_IRQ = 1'b0,
   localparam int XW      = (CW > LVL_W) ? CW : LVL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gie,
   input  logic             pend,
   input  logic             fie,
   input  logic             eie,
   input  logic [LVL_W-1:0] af_lvl,
   input  logic [LVL_W-1:0] ae_lvl,
   input  logic [CW-1:0]    rx_cnt,
   input  logic [CW-1:0]    tx_cnt,
   output logic             irq
);

   logic rx_hi, tx_lo, irq_d;

   assign rx_hi = fie && (XW'(rx_cnt) >= XW'(af_lvl));
   assign tx_lo = eie && (XW'(tx_cnt) <= XW'(ae_lvl));
   assign irq_d = gie && (pend || rx_hi || tx_lo);

   generate
      if (REG_IRQ) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq <= 1'b0;
            end else begin
               irq <= irq_d;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq = irq_d;
      end
   endgenerate

endmodule

// File: rtl/i2cm_csr_unit.sv
module i2cm_csr_unit
   import i2cm_csr_pkg::*;
#(
   parameter int          DEPTH   = 16,
   parameter int          CNT_W   = 16,
   parameter bit          REG_IRQ = 1'b0,
   parameter logic [31:0] VERSION = 32'h0001_0200,
   localparam int         CW      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic              eng_nack,
   input  logic              eng_tx_pop,
   input  logic              eng_rx_push,
   input  logic [7:0]        eng_rx_data,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic [7:0]        tx_byte,
   output logic              tx_avail,
   output logic              rx_space,
   output logic              cfg_start,
   output logic              cfg_enable,
   output logic              cfg_read,
   output logic              cfg_send_stop,
   output logic [4:0]        cfg_opts,
   output logic [6:0]        cfg_target,
   output logic [CNT_W-1:0]  cfg_count,
   output logic [15:0]       cfg_hs,
   output logic [31:0]       scl_high_cnt,
   output logic [31:0]       scl_low_cnt,
   output logic [31:0]       start_hold,
   output logic              irq
);

   generate
      if (DEPTH < 2 || DEPTH > 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two from 2 to 16");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must be 1 to 32");
      end
   endgenerate

   logic [31:0]      ctl_q, dvl_q, dvh_q, hld_q;
   logic [6:0]       tgt_q;
   logic [CNT_W-1:0] cnt_q;
   logic [15:0]      hsc_q;
   logic             pend_q, nack_q;

   logic             wr_acc, rd_acc;
   reg_idx_e         idx;
   logic             sts_wr, tx_push, rx_pop, flush;
   logic [7:0]       rx_head;
   logic [CW-1:0]    tx_cnt, rx_cnt;
   logic             tx_empty, tx_full, rx_empty, rx_full;
   logic [1:0]       unused_addr;

   assign unused_addr = bus_addr[1:0];
   assign idx     = reg_idx_e'(bus_addr[5:2]);
   assign wr_acc  = bus_sel && bus_en && bus_wr;
   assign rd_acc  = bus_sel && bus_en && !bus_wr;
   assign sts_wr  = wr_acc && (idx == RI_STS);
   assign tx_push = wr_acc && (idx == RI_TXP);
   assign rx_pop  = rd_acc && (idx == RI_RXP);
   assign flush   = wr_acc && (idx == RI_FRST) && bus_wdata[0];

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         tgt_q <= '0;
         cnt_q <= '0;
         hsc_q <= '0;
         dvl_q <= '0;
         dvh_q <= '0;
         hld_q <= '0;
      end else if (wr_acc) begin
         case (idx)
            RI_CTL:  ctl_q <= bus_wdata & CTL_WMASK;
            RI_TGT:  tgt_q <= bus_wdata[7:1];
            RI_CNT:  cnt_q <= bus_wdata[CNT_W-1:0];
            RI_HSC:  hsc_q <= bus_wdata[15:0];
            RI_DVL:  dvl_q <= bus_wdata;
            RI_DVH:  dvh_q <= bus_wdata;
            RI_HLD:  hld_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   // sticky status flags: engine set beats a clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         nack_q <= 1'b0;
      end else begin
         pend_q <= eng_done || (pend_q && !(sts_wr && !bus_wdata[SB_PEND]));
         nack_q <= eng_nack || (nack_q && !(sts_wr && !bus_wdata[SB_NACK]));
      end
   end

   i2cm_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (tx_push),
      .wdata (bus_wdata[7:0]),
      .pop   (eng_tx_pop),
      .rdata (tx_byte),
      .count (tx_cnt),
      .empty (tx_empty),
      .full  (tx_full)
   );

   i2cm_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (eng_rx_push),
      .wdata (eng_rx_data),
      .pop   (rx_pop),
      .rdata (rx_head),
      .count (rx_cnt),
      .empty (rx_empty),
      .full  (rx_full)
   );

   i2cm_irq_gen #(.CW(CW), .LVL_W(LVL_W), .REG_IRQ(REG_IRQ)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .gie    (ctl_q[CB_GIE]),
      .pend   (pend_q),
      .fie    (ctl_q[CB_FIE]),
      .eie    (ctl_q[CB_EIE]),
      .af_lvl (ctl_q[CB_AF_LO +: LVL_W]),
      .ae_lvl (ctl_q[CB_AE_LO +: LVL_W]),
      .rx_cnt (rx_cnt),
      .tx_cnt (tx_cnt),
      .irq    (irq)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (idx)
            RI_CTL:  bus_rdata = ctl_q;
            RI_TGT:  bus_rdata = {24'b0, tgt_q, 1'b0};
            RI_CNT:  bus_rdata = 32'(cnt_q);
            RI_RXP:  bus_rdata = rx_empty ? 32'b0 : {24'b0, rx_head};
            RI_STS: begin
               bus_rdata[SB_BUSY] = eng_busy;
               bus_rdata[SB_NACK] = nack_q;
               bus_rdata[SB_PEND] = pend_q;
               bus_rdata[SB_TXE]  = tx_empty;
               bus_rdata[SB_RXF]  = rx_full;
               bus_rdata[SB_SCL]  = scl_in;
               bus_rdata[SB_SDA]  = sda_in;
            end
            RI_HSC:  bus_rdata = {16'b0, hsc_q};
            RI_VER:  bus_rdata = VERSION;
            RI_DVL:  bus_rdata = dvl_q;
            RI_DVH:  bus_rdata = dvh_q;
            RI_HLD:  bus_rdata = hld_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   assign tx_avail      = !tx_empty;
   assign rx_space      = !rx_full;
   assign cfg_start     = ctl_q[CB_START];
   assign cfg_enable    = ctl_q[CB_EN];
   assign cfg_read      = ctl_q[CB_READ];
   assign cfg_send_stop = !ctl_q[CB_NOSTOP];
   assign cfg_opts      = {ctl_q[CB_DMA], ctl_q[CB_DVD], ctl_q[CB_OUT],
                           ctl_q[CB_TRIM], ctl_q[CB_HS]};
   assign cfg_target    = tgt_q;
   assign cfg_count     = cnt_q;
   assign cfg_hs        = hsc_q;
   assign scl_high_cnt  = {dvh_q[31:16], dvl_q[31:16]};
   assign scl_low_cnt   = {dvh_q[15:0], dvl_q[15:0]};
   assign start_hold    = hld_q;

endmodule

// File: rtl/i2cm_csr_chk.sv
module i2cm_csr_chk #(
   parameter int  DEPTH = 16,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_sel,
   input logic          bus_en,
   input logic          bus_wr,
   input logic [5:0]    bus_addr,
   input logic [31:0]   bus_wdata,
   input logic          eng_done,
   input logic          eng_nack,
   input logic          pend_q,
   input logic          nack_q,
   input logic [CW-1:0] tx_cnt,
   input logic [CW-1:0] rx_cnt,
   input logic          cfg_start,
   input logic          gie_q,
   input logic          irq
);

   localparam logic [CW-1:0] MAXC = CW'(DEPTH);

   logic wr_acc, sts_wr, ctl_wr, flush_wr;
   assign wr_acc   = bus_sel && bus_en && bus_wr;
   assign sts_wr   = wr_acc && (bus_addr[5:2] == 4'd5);
   assign ctl_wr   = wr_acc && (bus_addr[5:2] == 4'd0);
   assign flush_wr = wr_acc && (bus_addr[5:2] == 4'd11) && bus_wdata[0];

   assert_done_sets_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> pend_q);
   assert_nack_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_nack |=> nack_q);
   assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !(sts_wr && !bus_wdata[2])) |=> pend_q);
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= MAXC);
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cnt <= MAXC);
   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_wr |=> (tx_cnt == '0 && rx_cnt == '0));
   assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!gie_q && !$past(gie_q)) |-> !irq);
   assert_start_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_start && !ctl_wr) |=> cfg_start);

endmodule

bind i2cm_csr_unit i2cm_csr_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_en    (bus_en),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .eng_done  (eng_done),
   .eng_nack  (eng_nack),
   .pend_q    (pend_q),
   .nack_q    (nack_q),
   .tx_cnt    (tx_cnt),
   .rx_cnt    (rx_cnt),
   .cfg_start (cfg_start),
   .gie_q     (ctl_q[1]),
   .irq       (irq)
);

// File: tb/tb_i2cm_csr_unit.sv
module tb_i2cm_csr_unit;

   localparam int          DEPTH = 16;
   localparam logic [31:0] VER   = 32'h0001_0200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 0, bus_en = 0, bus_wr = 0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        eng_busy = 0, eng_done = 0, eng_nack = 0;
   logic        eng_tx_pop = 0, eng_rx_push = 0;
   logic [7:0]  eng_rx_data = '0;
   logic        scl_in = 1, sda_in = 1;
   logic [7:0]  tx_byte;
   logic        tx_avail, rx_space, cfg_start, cfg_enable, cfg_read, cfg_send_stop;
   logic [4:0]  cfg_opts;
   logic [6:0]  cfg_target;
   logic [15:0] cfg_count, cfg_hs;
   logic [31:0] scl_high_cnt, scl_low_cnt, start_hold;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   i2cm_csr_unit #(.DEPTH(DEPTH), .VERSION(VER)) dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bw(input logic [5:0] a, input logic [31:0] d, input bit with_done = 0,
                     input bit with_nack = 0);
      @(negedge clk);
      bus_sel = 1; bus_en = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1; eng_done = with_done; eng_nack = with_nack;
      @(negedge clk);
      bus_sel = 0; bus_en = 0; bus_wr = 0; eng_done = 0; eng_nack = 0;
   endtask

   task automatic br(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_en = 0; bus_wr = 0; bus_addr = a;
      @(negedge clk);
      bus_en = 1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0; bus_en = 0;
   endtask

   task automatic pulse_done();
      @(negedge clk); eng_done = 1;
      @(negedge clk); eng_done = 0;
   endtask

   task automatic pop_tx();
      @(negedge clk); eng_tx_pop = 1;
      @(negedge clk); eng_tx_pop = 0;
   endtask

   task automatic push_rx(input logic [7:0] b);
      @(negedge clk); eng_rx_push = 1; eng_rx_data = b;
      @(negedge clk); eng_rx_push = 0;
   endtask

   function automatic logic irq_model(input logic [31:0] ctl, input logic pend,
                                      input int txc, input int rxc);
      logic g, fe, ee;
      int af, ae;
      g  = ctl[1];
      ee = ctl[9];
      fe = ctl[10];
      ae = int'(ctl[15:12]);
      af = int'(ctl[19:16]);
      return g && (pend || (fe && rxc >= af) || (ee && txc <= ae));
   endfunction

   initial begin
      #(4 * 150000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] ctl_m;
      int m_tx, m_rx;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      br(6'h00, rd); check("R1 ctl reset", rd, 32'h0);
      br(6'h14, rd); check("R1 status reset", rd, 32'h0030_0008);
      br(6'h1C, rd); check("R1 version", rd, VER);
      check("R1 irq reset", {31'b0, irq}, 32'h0);

      // R2 control mask and outputs
      bw(6'h00, 32'hFFFF_FFFF);
      br(6'h00, rd); check("R2 ctl mask", rd, 32'h001F_FFDF);
      check("R2 cfg outs", {27'b0, cfg_start, cfg_enable, cfg_read, 2'b0}, 32'h1C);
      check("R2 opts", {27'b0, cfg_opts}, 32'h1F);
      check("R12 stop suppressed", {31'b0, cfg_send_stop}, 32'h0);
      bw(6'h00, 32'h0000_0000);
      check("R12 stop requested", {31'b0, cfg_send_stop}, 32'h1);

      // R3 target / count / hs
      bw(6'h04, 32'h0000_00FF);
      br(6'h04, rd); check("R3 target read", rd, 32'h0000_00FE);
      check("R3 cfg_target", {25'b0, cfg_target}, 32'h7F);
      bw(6'h08, 32'hFFFF_1234);
      br(6'h08, rd); check("R3 count", rd, 32'h0000_1234);
      bw(6'h18, 32'hABCD_5678);
      br(6'h18, rd); check("R3 hs cfg", rd, 32'h0000_5678);

      // R4 version read-only
      bw(6'h1C, 32'hDEAD_BEEF);
      br(6'h1C, rd); check("R4 version write ignored", rd, VER);

      // R10 dividers and hold
      bw(6'h20, 32'hAAAA_BBBB);
      bw(6'h24, 32'hCCCC_DDDD);
      bw(6'h28, 32'h0000_0068);
      check("R10 high", scl_high_cnt, 32'hCCCC_AAAA);
      check("R10 low", scl_low_cnt, 32'hDDDD_BBBB);
      check("R10 hold", start_hold, 32'h68);

      // R5 status set / clear / collision
      pulse_done();
      br(6'h14, rd); check("R5 pend set", {31'b0, rd[2]}, 32'h1);
      bw(6'h14, 32'h0000_0004);
      br(6'h14, rd); check("R5 write1 keeps", {31'b0, rd[2]}, 32'h1);
      bw(6'h14, 32'h0000_0000, 1'b1, 1'b1);
      br(6'h14, rd); check("R5 collision set wins", {30'b0, rd[2:1]}, 32'h3);
      bw(6'h14, 32'h0000_0000);
      br(6'h14, rd); check("R5 write0 clears", {30'b0, rd[2:1]}, 32'h0);

      // R11 start held across done
      bw(6'h00, 32'h0000_0005);
      pulse_done();
      repeat (4) @(negedge clk);
      check("R11 start held", {31'b0, cfg_start}, 32'h1);
      bw(6'h00, 32'h0000_0004);
      check("R11 start cleared by sw", {31'b0, cfg_start}, 32'h0);
      bw(6'h14, 32'h0);

      // R6 TX order and drop when full
      for (int i = 0; i <= DEPTH; i++) bw(6'h10, 32'h100 + i);
      for (int i = 0; i < DEPTH; i++) begin
         check("R6 tx order", {24'b0, tx_byte}, 32'(i));
         pop_tx();
      end
      check("R6 tx drained after drop", {31'b0, tx_avail}, 32'h0);

      // R7 RX order, full flag, empty read
      for (int i = 0; i <= DEPTH; i++) push_rx(8'(8'h40 + i));
      br(6'h14, rd); check("R7 rx full flag", {31'b0, rd[4]}, 32'h1);
      for (int i = 0; i < DEPTH; i++) begin
         br(6'h0C, rd); check("R7 rx order", rd, 32'(8'h40 + i));
      end
      br(6'h0C, rd); check("R7 empty read", rd, 32'h0);

      // R8 flush
      bw(6'h10, 32'h11); bw(6'h10, 32'h22);
      push_rx(8'h33);
      bw(6'h2C, 32'h1);
      check("R8 tx flushed", {31'b0, tx_avail}, 32'h0);
      br(6'h0C, rd); check("R8 rx flushed", rd, 32'h0);

      // R9 random irq
      m_tx = 0; m_rx = 0; ctl_m = 0;
      for (int it = 0; it < 400; it++) begin
         case ($urandom % 5)
            0: begin
               ctl_m = $urandom & 32'h000F_F602;
               bw(6'h00, ctl_m);
            end
            1: begin
               bw(6'h10, $urandom);
               if (m_tx < DEPTH) m_tx++;
            end
            2: begin
               pop_tx();
               if (m_tx > 0) m_tx--;
            end
            3: begin
               push_rx(8'($urandom));
               if (m_rx < DEPTH) m_rx++;
            end
            default: begin
               br(6'h0C, rd);
               if (m_rx > 0) m_rx--;
            end
         endcase
         @(negedge clk);
         check("R9 irq", {31'b0, irq}, {31'b0, irq_model(ctl_m, 1'b0, m_tx, m_rx)});
      end
      bw(6'h00, 32'h0000_0002);
      pulse_done();
      check("R9 irq from pending", {31'b0, irq}, 32'h1);
      bw(6'h14, 32'h0);
      check("R9 irq after clear", {31'b0, irq},
            {31'b0, irq_model(32'h2, 1'b0, m_tx, m_rx)});

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule